// File: doc/BRIEF.md
# Stop-mode wakeup sequencer

This block decides how a small microcontroller comes back from its two deep stop modes. Software requests stop through `stop_req` with a mode bit. One mode keeps every register, logic, memory and pin state. The other mode powers the core down and loses that state. While stopped, the block turns off the regulator and the clock and holds the core. It waits for an exit trigger: the reset pin, or a wakeup interrupt source whose enable bit is set. It then brings the machine back up in fixed phases. First it waits for the regulator to report ready. Next it enables the clock and waits for the clock generator to report valid. Then it counts a settle-and-processing window of clock cycles. Last, it releases the core with a one-cycle start pulse tagged for the reset vector or the interrupt vector.

The length of the counted window depends on the exit path. An interrupt exit from the retaining mode resumes through the interrupt vector. It needs 28 valid clock cycles: 6 cycles for the restarted clock to settle, plus 11 bus cycles of stacking and vector fetch at half the clock rate. Every exit from the power-down mode, and every exit caused by the reset pin, goes through the full power-on reset sequence. That sequence is 150 valid clock cycles and ends at the reset vector. Cycles are counted on `clk`, one count per cycle in which `clk_valid` is high. If `clk_valid` drops, the count starts again from zero.

States: `ST_RUN` (core running), `ST_STOP` (asleep), `ST_REG_WAIT` (regulator on, clock off), `ST_CLK_RUN` (clock on, window counting), `ST_START` (start pulse). Transitions:
- `ST_RUN` to `ST_STOP` on `stop_req`.
- `ST_STOP` to `ST_REG_WAIT` on an exit trigger.
- `ST_REG_WAIT` to `ST_CLK_RUN` on `reg_ready`.
- `ST_CLK_RUN` to `ST_START` when the window count completes.
- `ST_START` to `ST_RUN` always.

Top module: `stop_wake_seq`

## Requirements
- R1: After reset the block is in the running state: `reg_en`=1, `clk_en`=1, `core_hold`=0, `start_pulse`=0.
- R2: A `stop_req` sampled while running enters stop on that edge. From the next cycle, `reg_en`=0, `clk_en`=0 and `core_hold`=1. `stop_mode` is latched at the same edge: 0 selects the state-retaining mode, 1 the power-down mode.
- R3: While stopped, a `wake_src` bit whose `wake_en` bit is 0 has no effect. The outputs stay in the stopped state.
- R4: On an exit trigger, `reg_en` rises and `clk_en` stays 0 until `reg_ready` is sampled high. The clock is never enabled while the regulator is off.
- R5: After `reg_ready` is seen, `clk_en`=1. The window counts only cycles with `clk_valid`=1, and a cycle with `clk_valid`=0 restarts the count from zero.
- R6: An enabled interrupt exit from the retaining mode gives `start_pulse` with `start_irq`=1 after 28 counted cycles. With `reg_ready` and `clk_valid` held high, the pulse appears 30 cycles after the trigger edge.
- R7: A reset-pin exit (`pin_reset`=1) gives `start_irq`=0 after 150 counted cycles.
- R8: Any exit from the power-down mode, including an enabled interrupt, is a reset exit: `start_irq`=0 after 150 counted cycles.
- R9: If `pin_reset` and an enabled interrupt are present on the same edge, the reset exit wins.
- R10: `start_pulse` lasts exactly one cycle. During the pulse, `core_hold`=0 and both enables are 1, and the block is running on the next cycle.
- R11: A `stop_req` that arrives during a wakeup is ignored. The wakeup completes on time and the block stays running afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; one counted cycle per period |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Request to enter stop |
| stop_mode | input | 1 | 0 = state-retaining stop, 1 = power-down stop |
| pin_reset | input | 1 | Reset pin asserted (active high) |
| wake_src | input | NSRC | Wakeup interrupt requests, one per source |
| wake_en | input | NSRC | Per-source wakeup enable mask |
| reg_ready | input | 1 | Regulator has recovered |
| clk_valid | input | 1 | Clock generator output is valid |
| reg_en | output | 1 | Regulator enable |
| clk_en | output | 1 | Clock generator enable |
| core_hold | output | 1 | Holds the core off |
| start_pulse | output | 1 | One-cycle release of the core |
| start_irq | output | 1 | Vector tag with the pulse: 1 = interrupt vector, 0 = reset vector |

## Verification
On every cycle, the assertions check the ordering rules between the outputs. The clock never runs with the regulator off. The clock is only enabled after a regulator-ready cycle. A request cannot pull an active wakeup back into stop. The start pulse is a single cycle with the core released. A counter fed only by `clk_valid` confirms the exact window length for the vector tag that comes with each pulse. Only the bench scenarios can show the things that depend on which trigger occurred and when: disabled sources not waking the part, the reset pin winning over a simultaneous interrupt, power-down turning an interrupt into a reset exit, and the exact latency after a `clk_valid` dropout or a late `reg_ready`.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_STOP,
        ST_REG_WAIT,
        ST_CLK_RUN,
        ST_START
    } wake_state_e;

    typedef enum logic {
        MODE_RETAIN    = 1'b0,
        MODE_POWERDOWN = 1'b1
    } stop_mode_e;

endpackage

// File: rtl/wake_trigger.sv
module wake_trigger #(
    parameter int NSRC = 8
) (
    input  logic            pin_reset,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    output logic            exit_hit,
    output logic            irq_only
);

    logic [NSRC-1:0] qualified;

    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        assign qualified[g] = src[g] & en[g];
    end

    // The reset pin outranks any interrupt source (R9).
    assign exit_hit = pin_reset | (|qualified);
    assign irq_only = !pin_reset && (|qualified);

endmodule

// File: rtl/wake_counter.sv
module wake_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          valid,
    input  logic [CW-1:0] target,
    output logic          done
);

    logic [CW-1:0] cnt;

    // Consecutive valid cycles; a gap restarts the window (R5).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !valid) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = valid && (cnt == target - CW'(1));

endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
    import stop_wake_pkg::*;
#(
    parameter int NSRC        = 8,
    parameter int CLK_SETTLE  = 6,
    parameter int IRQ_BUS_CYC = 11,
    parameter int BUS_DIV     = 2,
    parameter int POR_CYCLES  = 150
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req,
    input  logic            stop_mode,
    input  logic            pin_reset,
    input  logic [NSRC-1:0] wake_src,
    input  logic [NSRC-1:0] wake_en,
    input  logic            reg_ready,
    input  logic            clk_valid,
    output logic            reg_en,
    output logic            clk_en,
    output logic            core_hold,
    output logic            start_pulse,
    output logic            start_irq
);

    localparam int IRQ_CYCLES = CLK_SETTLE + IRQ_BUS_CYC * BUS_DIV;
    localparam int MAX_CYCLES = (IRQ_CYCLES > POR_CYCLES) ? IRQ_CYCLES : POR_CYCLES;
    localparam int CW         = $clog2(MAX_CYCLES + 1);

    wake_state_e   state, nxt;
    stop_mode_e    mode_q;
    logic          irq_q;
    logic [CW-1:0] target_q;
    logic          exit_hit, irq_only, take_irq, win_done;

    wake_trigger #(.NSRC(NSRC)) i_trig (
        .pin_reset (pin_reset),
        .src       (wake_src),
        .en        (wake_en),
        .exit_hit  (exit_hit),
        .irq_only  (irq_only)
    );

    // Power-down stop always comes back through the reset path (R8).
    assign take_irq = irq_only && (mode_q == MODE_RETAIN);

    wake_counter #(.CW(CW)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state != ST_CLK_RUN),
        .valid  (clk_valid),
        .target (target_q),
        .done   (win_done)
    );

    // State register and exit-path latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            mode_q   <= MODE_RETAIN;
            irq_q    <= 1'b0;
            target_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && stop_req) begin
                mode_q <= stop_mode_e'(stop_mode);
            end
            if (state == ST_STOP && exit_hit) begin
                irq_q    <= take_irq;
                target_q <= take_irq ? CW'(IRQ_CYCLES) : CW'(POR_CYCLES);
            end
        end
    end

    // Transitions; stop_req is only looked at in ST_RUN (R11).
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (stop_req)  nxt = ST_STOP;
            ST_STOP:     if (exit_hit)  nxt = ST_REG_WAIT;
            ST_REG_WAIT: if (reg_ready) nxt = ST_CLK_RUN;
            ST_CLK_RUN:  if (win_done)  nxt = ST_START;
            ST_START:                   nxt = ST_RUN;
            default:                    nxt = ST_RUN;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        reg_en      = 1'b1;
        clk_en      = 1'b1;
        core_hold   = 1'b0;
        start_pulse = 1'b0;
        start_irq   = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_STOP: begin
                reg_en    = 1'b0;
                clk_en    = 1'b0;
                core_hold = 1'b1;
            end
            ST_REG_WAIT: begin
                clk_en    = 1'b0;
                core_hold = 1'b1;
            end
            ST_CLK_RUN: begin
                core_hold = 1'b1;
            end
            ST_START: begin
                start_pulse = 1'b1;
                start_irq   = irq_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk #(
    parameter int IRQ_CYCLES = 28,
    parameter int POR_CYCLES = 150
) (
    input logic clk,
    input logic rst_n,
    input logic reg_en,
    input logic clk_en,
    input logic core_hold,
    input logic start_pulse,
    input logic start_irq,
    input logic reg_ready,
    input logic clk_valid
);

    logic [15:0] vcnt;

    // Independent run length of valid clock cycles while the window is open.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (core_hold && clk_en) begin
            vcnt <= clk_valid ? vcnt + 16'd1 : 16'd0;
        end else begin
            vcnt <= '0;
        end
    end

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> core_hold);

    p_clock_after_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> !clk_en);

    p_ready_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && $rose(clk_en)) |-> $past(reg_ready));

    p_irq_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |-> start_pulse);

    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (vcnt == (start_irq ? 16'(IRQ_CYCLES) : 16'(POR_CYCLES))));

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    p_pulse_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (!core_hold && reg_en && clk_en));

    p_no_restop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && clk_en) |=> ((core_hold && clk_en) || start_pulse));

endmodule

bind stop_wake_seq stop_wake_chk #(
    .IRQ_CYCLES (IRQ_CYCLES),
    .POR_CYCLES (POR_CYCLES)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_en      (reg_en),
    .clk_en      (clk_en),
    .core_hold   (core_hold),
    .start_pulse (start_pulse),
    .start_irq   (start_irq),
    .reg_ready   (reg_ready),
    .clk_valid   (clk_valid)
);

// File: tb/test_stop_wake_seq.sv
module test_stop_wake_seq;

    localparam int IRQ_N = 6 + 2 * 11;
    localparam int POR_N = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0, stop_mode = 1'b0, pin_reset = 1'b0;
    logic [7:0] wake_src = 8'h00, wake_en = 8'h05;
    logic       reg_ready = 1'b1, clk_valid = 1'b1;
    logic       reg_en, clk_en, core_hold, start_pulse, start_irq;

    int  checks = 0, fails = 0;
    bit  done_flag = 1'b0;

    always #2 clk = ~clk;

    stop_wake_seq i_stop_wake_seq (
        .clk, .rst_n, .stop_req, .stop_mode, .pin_reset, .wake_src, .wake_en,
        .reg_ready, .clk_valid, .reg_en, .clk_en, .core_hold, .start_pulse, .start_irq
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 awake, 1 asleep, 2 regulator, 3 clock window, 4 release.
    int ph = 0, need = 0, run = 0;
    bit m_irq = 0, m_pd = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; need = 0; run = 0; m_irq = 0; m_pd = 0;
        end else begin
            case (ph)
                0: if (stop_req) begin m_pd = stop_mode; ph = 1; end
                1: if (pin_reset || ((wake_src & wake_en) != 0)) begin
                       m_irq = !m_pd && !pin_reset;
                       need  = m_irq ? IRQ_N : POR_N;
                       run   = 0;
                       ph    = 2;
                   end
                2: if (reg_ready) ph = 3;
                3: begin
                       run = clk_valid ? run + 1 : 0;
                       if (run == need) ph = 4;
                   end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            automatic int exp_v = {ph != 1, (ph == 0 || ph >= 3), (ph >= 1 && ph <= 3),
                                   ph == 4, (ph == 4 && m_irq)};
            automatic int act_v = {reg_en, clk_en, core_hold, start_pulse, start_irq};
            automatic string tag = (ph == 0) ? "R1 model" : (ph == 1) ? "R2 model" :
                                   (ph == 2) ? "R4 model" : (ph == 3) ? "R5 model" : "R10 model";
            check(act_v == exp_v, tag, act_v, exp_v);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_stop(input bit pd);
        stop_req = 1'b1; stop_mode = pd;
        tick(1);
        stop_req = 1'b0;
        tick(1);
        check(!reg_en && !clk_en && core_hold, "R2 stopped", {reg_en, clk_en, core_hold}, 3'b001);
    endtask

    // Applies a trigger and counts negedges until the start pulse.
    task automatic run_wake(input bit pin, input logic [7:0] src, input int drop_at,
                            input int req_at, input int ready_at,
                            output int n, output bit irq);
        n = 0;
        if (ready_at > 0) reg_ready = 1'b0;
        pin_reset = pin; wake_src = src;
        while (n < 400) begin
            tick(1);
            n++;
            if (n == 1) begin pin_reset = 1'b0; wake_src = 8'h00; end
            if (drop_at > 0 && n == drop_at) clk_valid = 1'b0;
            if (drop_at > 0 && n == drop_at + 1) clk_valid = 1'b1;
            if (req_at > 0) stop_req = (n >= req_at && n < req_at + 3);
            if (ready_at > 0 && n == ready_at - 1)
                check(reg_en && !clk_en, "R4 regulator before clock", {reg_en, clk_en}, 2'b10);
            if (ready_at > 0 && n == ready_at) reg_ready = 1'b1;
            if (start_pulse) break;
        end
        irq = start_irq;
        stop_req = 1'b0;
        tick(1);
        check(!start_pulse && !core_hold && reg_en && clk_en, "R10 release",
              {start_pulse, core_hold, reg_en, clk_en}, 4'b0011);
    endtask

    initial begin
        int n;
        bit irq;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(reg_en && clk_en && !core_hold && !start_pulse, "R1 reset state",
              {reg_en, clk_en, core_hold, start_pulse}, 4'b1100);

        // R3 then R6: disabled source ignored, enabled source wakes via interrupt vector.
        go_stop(1'b0);
        wake_src = 8'h02;
        tick(5);
        check(!reg_en && core_hold, "R3 disabled source", {reg_en, core_hold}, 2'b01);
        wake_src = 8'h00;
        run_wake(1'b0, 8'h04, 0, 0, 0, n, irq);
        check(n == IRQ_N + 2, "R6 latency", n, IRQ_N + 2);
        check(irq == 1'b1, "R6 vector", irq, 1);

        // R7: reset pin exit from retaining mode.
        go_stop(1'b0);
        run_wake(1'b1, 8'h00, 0, 0, 0, n, irq);
        check(n == POR_N + 2, "R7 latency", n, POR_N + 2);
        check(irq == 1'b0, "R7 vector", irq, 0);

        // R8: interrupt exit from power-down becomes a reset exit.
        go_stop(1'b1);
        run_wake(1'b0, 8'h01, 0, 0, 0, n, irq);
        check(n == POR_N + 2, "R8 latency", n, POR_N + 2);
        check(irq == 1'b0, "R8 vector", irq, 0);

        // R9: pin and interrupt on the same edge.
        go_stop(1'b0);
        run_wake(1'b1, 8'h01, 0, 0, 0, n, irq);
        check(n == POR_N + 2, "R9 latency", n, POR_N + 2);
        check(irq == 1'b0, "R9 vector", irq, 0);

        // R4: late regulator ready stretches the wakeup.
        go_stop(1'b0);
        run_wake(1'b0, 8'h04, 0, 0, 7, n, irq);
        check(n == IRQ_N + 8, "R4 latency", n, IRQ_N + 8);

        // R5: a valid-clock gap after three counted cycles restarts the window.
        go_stop(1'b0);
        run_wake(1'b0, 8'h01, 5, 0, 0, n, irq);
        check(n == IRQ_N + 6, "R5 latency", n, IRQ_N + 6);

        // R11: stop request during the window is ignored.
        go_stop(1'b0);
        run_wake(1'b0, 8'h04, 0, 10, 0, n, irq);
        check(n == IRQ_N + 2, "R11 latency", n, IRQ_N + 2);
        tick(3);
        check(reg_en && clk_en && !core_hold, "R11 still running",
              {reg_en, clk_en, core_hold}, 3'b110);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule